// File: doc/BRIEF.md
# Dual-Clock Buffer with Programmable Level Flags

This block is an 18-bit first-in first-out buffer. Its write side and its read side each have their own free-running clock and their own enable. The two clocks may be tied together, or they may run with no phase relationship at all. A word enters on every write-clock rising edge that has the write enable high. A word leaves on every read-clock rising edge that has the read enable high. The storage is an inferred dual-port register array. Its depth is a power-of-two parameter, and it defaults to 1024 words.

Five level flags report how much the buffer holds:
- full and empty;
- half-full;
- almost-full and almost-empty, whose thresholds come from two threshold registers loaded on the write clock.

A retransmit input sends the read side back to address zero, so that data already read can be read again. An output-enable input gates the registered read word. When the enable is low, the read-data pins float.

Pointers cross between the clock domains as Gray codes through two-flop synchronizers:
- full, half-full and almost-full are computed in the write domain;
- empty and almost-empty are computed in the read domain.

The threshold registers are meant to be loaded while the buffer is idle, because almost-empty reads its threshold across the clock boundary.

Top module: `dcf_fifo`

## Requirements
- R1: While reset is low and just after it is released: empty=1, full=0, half-full=0, almost-full=0, almost-empty=1, and both threshold registers hold 7.
- R2: Each write-clock edge with `wen`=1 and full=0 stores `din`. Each read-clock edge with `ren`=1, empty=0 and `rt`=0 loads the oldest unread word into the read register. Words come out in the order they went in.
- R3: A write attempted while full=1 is ignored. The stored words and the level are unchanged.
- R4: A read attempted while empty=1 is ignored. The read register keeps its previous word.
- R5: Full rises at the write edge that brings the level to DEPTH, with no added delay.
- R6: After a write into an empty buffer, empty stays high when sampled after that write edge and after the next read edge. It falls after the second read-clock edge that follows the write. Empty rises at the read edge that takes the last word.
- R7: Half-full is 1 exactly when the level exceeds DEPTH/2.
- R8: Almost-empty is 1 exactly when the level is at or below the empty threshold.
- R9: Almost-full is 1 exactly when the free space (DEPTH minus level) is at or below the full threshold.
- R10: On a write-clock edge with `ofs_ld`=1, `ofs_val` is loaded into the empty threshold when `ofs_sel`=0, or into the full threshold when `ofs_sel`=1.
- R11: A read-clock edge with `rt`=1 sets the read address back to zero. This takes priority over `ren`. Later reads replay the words from the first word written since reset, provided fewer than DEPTH words have been written since reset.
- R12: With `oe`=1, `q` shows the read register. With `oe`=0, `q` is high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wen | input | 1 | Write enable |
| din | input | DW (18) | Write data |
| ren | input | 1 | Read enable |
| rt | input | 1 | Retransmit: rewind the read side to address zero |
| oe | input | 1 | Output enable for `q` |
| q | output | DW (18) | Registered read data, high-impedance when `oe`=0 |
| ofs_ld | input | 1 | Load a threshold register (write clock) |
| ofs_sel | input | 1 | 0 selects the empty threshold, 1 selects the full threshold |
| ofs_val | input | AW | Threshold value to load |
| full | output | 1 | Level equals DEPTH (write domain) |
| empty | output | 1 | Level is zero (read domain) |
| hf | output | 1 | Level above DEPTH/2 (write domain) |
| af | output | 1 | Free space at or below the full threshold (write domain) |
| ae | output | 1 | Level at or below the empty threshold (read domain) |

## Verification
Results fall due at three different times:
- **Write-domain flags** (full, half-full and almost-full) settle right after the write edge that changes the level, because they come combinationally from the local pointer and the synchronized far pointer.
- **Read word**: the read register updates at the read edge that accepts the read.
- **Read-domain flags**: a write reaches empty and almost-empty only after two read-clock edges through the synchronizer.

The bench ties both clocks to one 125 MHz source and drives and samples 2 ns after each rising edge. It checks each word right after the edge that read it. It checks the empty latency on each of the three edges that follow a write. Between level changes it idles four cycles, so that both flag domains have settled before the flags are compared.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Binary to reflected Gray code.
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Reflected Gray code back to binary.
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    for (int i = 0; i < 32; i++) begin
      b[i] = ^(g >> i);
    end
    return b;
  endfunction

  // Words held, given head and tail pointers that carry one wrap bit.
  function automatic logic [31:0] level_of(input logic [31:0] head,
                                           input logic [31:0] tail,
                                           input int unsigned pw);
    logic [31:0] mask;
    mask = (32'd1 << pw) - 32'd1;
    return (head - tail) & mask;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wen,
  input  logic [AW:0]   rgray_s,
  input  logic [AW-1:0] af_ofs,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          wr_fire,
  output logic          full,
  output logic          hf,
  output logic          af
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

  logic [PW-1:0] wbin;
  logic [PW-1:0] wbin_nx;
  logic [PW-1:0] rbin_s;
  logic [PW-1:0] wlvl;
  logic [PW-1:0] wfree;
  logic          wr_block;

  assign rbin_s   = PW'(from_gray(32'(rgray_s)));
  assign wlvl     = PW'(level_of(32'(wbin), 32'(rbin_s), PW));
  assign wfree    = DEPTH_P - wlvl;
  assign full     = (wlvl == DEPTH_P);
  assign hf       = (wlvl > HALF_P);
  assign af       = (wfree <= {1'b0, af_ofs});
  assign wr_fire  = wen & ~full;
  assign wr_block = wen & full;
  assign wbin_nx  = wbin + PW'(1);
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_fire) begin
      wbin  <= wbin_nx;
      wgray <= PW'(to_gray(32'(wbin_nx)));
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_block |=> $stable(wbin));  // R3
  AST_FULL_AFTER_WRITE: assert property (@(posedge wclk) disable iff (!rst_n)
    $rose(full) |-> $past(wr_fire));  // R5
  AST_AF_WHEN_FULL: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> (af && hf));  // R9
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          ren,
  input  logic          rt,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ae_ofs,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] raddr,
  output logic          rd_fire,
  output logic          empty,
  output logic          ae
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin;
  logic [PW-1:0] rbin_nx;
  logic [PW-1:0] wbin_s;
  logic [PW-1:0] rlvl;
  logic          rd_block;

  assign wbin_s   = PW'(from_gray(32'(wgray_s)));
  assign rlvl     = PW'(level_of(32'(wbin_s), 32'(rbin), PW));
  assign empty    = (rlvl == '0);
  assign ae       = (rlvl <= {1'b0, ae_ofs});
  assign rd_fire  = ren & ~empty & ~rt;
  assign rd_block = ren & empty & ~rt;
  assign rbin_nx  = rbin + PW'(1);
  assign raddr    = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rt) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_fire) begin
      rbin  <= rbin_nx;
      rgray <= PW'(to_gray(32'(rbin_nx)));
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_block |=> $stable(rbin));  // R4
  AST_RT_REWIND: assert property (@(posedge rclk) disable iff (!rst_n)
    rt |=> (rbin == '0));  // R11
  AST_AE_WHEN_EMPTY: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |-> ae);  // R8
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter int DW      = 18,
  parameter int DEPTH   = 1024,
  parameter int DEF_OFS = 7,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wen,
  input  logic [DW-1:0] din,
  input  logic          ren,
  input  logic          rt,
  input  logic          oe,
  output logic [DW-1:0] q,
  input  logic          ofs_ld,
  input  logic          ofs_sel,
  input  logic [AW-1:0] ofs_val,
  output logic          full,
  output logic          empty,
  output logic          hf,
  output logic          af,
  output logic          ae
);
  localparam int PW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q_reg;
  logic [AW-1:0] ae_ofs;
  logic [AW-1:0] af_ofs;
  logic [PW-1:0] wgray;
  logic [PW-1:0] rgray;
  logic [PW-1:0] wgray_s;
  logic [PW-1:0] rgray_s;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic          wr_fire;
  logic          rd_fire;
  logic          ld_empty_ofs;
  logic          ld_full_ofs;

  assign ld_empty_ofs = ofs_ld & ~ofs_sel;
  assign ld_full_ofs  = ofs_ld &  ofs_sel;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      ae_ofs <= AW'(DEF_OFS);
      af_ofs <= AW'(DEF_OFS);
    end else begin
      if (ld_empty_ofs) ae_ofs <= ofs_val;
      if (ld_full_ofs)  af_ofs <= ofs_val;
    end
  end

  dcf_wr_ctl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wen(wen), .rgray_s(rgray_s),
    .af_ofs(af_ofs), .wgray(wgray), .waddr(waddr), .wr_fire(wr_fire),
    .full(full), .hf(hf), .af(af)
  );

  dcf_rd_ctl #(.AW(AW)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .ren(ren), .rt(rt), .wgray_s(wgray_s),
    .ae_ofs(ae_ofs), .rgray(rgray), .raddr(raddr), .rd_fire(rd_fire),
    .empty(empty), .ae(ae)
  );

  dcf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  dcf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[waddr] <= din;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)       q_reg <= '0;
    else if (rd_fire) q_reg <= mem[raddr];
  end

  assign q = oe ? q_reg : {DW{1'bz}};

  AST_OFS_LOAD: assert property (@(posedge wclk) disable iff (!rst_n)
    ld_empty_ofs |=> (ae_ofs == $past(ofs_val)));  // R10
  AST_QREG_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_fire |=> $stable(q_reg));  // R4
endmodule

// File: tb/tb_dcf_fifo.sv
module tb_dcf_fifo;
  localparam int DW    = 18;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wen = 1'b0, ren = 1'b0, rt = 1'b0, oe = 1'b1;
  logic [DW-1:0] din = '0;
  logic          ofs_ld = 1'b0, ofs_sel = 1'b0;
  logic [AW-1:0] ofs_val = '0;
  wire  [DW-1:0] q;
  logic          full, empty, hf, af, ae;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [DW-1:0] mq[$];
  logic [DW-1:0] hist[$];
  logic [DW-1:0] dval = 18'h1000;
  logic [DW-1:0] last_q = '0;
  int aeo = 7, afo = 7;

  // Vector fields: writes[20:13], reads[12:5], {full,empty,hf,af,ae}[4:0]
  localparam logic [20:0] VEC [6] = '{
    {8'd3, 8'd0,  5'b00001},
    {8'd6, 8'd0,  5'b00110},
    {8'd7, 8'd0,  5'b10110},
    {8'd2, 8'd0,  5'b10110},
    {8'd0, 8'd10, 5'b00001},
    {8'd0, 8'd8,  5'b01001}
  };

  dcf_fifo #(.DW(DW), .DEPTH(DEPTH), .DEF_OFS(7)) dut (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .wen(wen), .din(din), .ren(ren),
    .rt(rt), .oe(oe), .q(q), .ofs_ld(ofs_ld), .ofs_sel(ofs_sel),
    .ofs_val(ofs_val), .full(full), .empty(empty), .hf(hf), .af(af), .ae(ae)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [4:0] flags_of(input int occ);
    logic [4:0] f;
    f[4] = (occ == DEPTH);
    f[3] = (occ == 0);
    f[2] = (occ > DEPTH / 2);
    f[1] = ((DEPTH - occ) <= afo);
    f[0] = (occ <= aeo);
    return f;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    wen = 0; ren = 0; rt = 0; ofs_ld = 0;
    mq.delete(); hist.delete();
    aeo = 7; afo = 7; last_q = '0;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic wr(input int n);
    for (int i = 0; i < n; i++) begin
      wen = 1'b1; din = dval;
      cyc();
      if (mq.size() < DEPTH) begin
        mq.push_back(dval); hist.push_back(dval);
      end
      dval = dval + 18'h1;
    end
    wen = 1'b0;
  endtask

  task automatic rd(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      ren = 1'b1;
      cyc();
      if (mq.size() > 0) last_q = mq.pop_front();
      chk(req, 32'(q), 32'(last_q));
    end
    ren = 1'b0;
  endtask

  task automatic settle();
    repeat (4) cyc();
  endtask

  task automatic chk_flags(input string req, input logic [4:0] exp);
    chk(req, 32'({full, empty, hf, af, ae}), 32'(exp));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    #3;
    chk_flags("R1 flags in reset", 5'b01001);
    do_reset();
    chk_flags("R1 flags after reset", 5'b01001);

    // Vector table: R2 R3 R4 R5 R7 R8 R9
    for (int v = 0; v < 6; v++) begin
      wr(int'(VEC[v][20:13]));
      if (v == 2) chk("R5 full right after last write", 32'(full), 32'd1);
      rd("R2 R3 R4 read order", int'(VEC[v][12:5]));
      settle();
      chk_flags("R7 R8 R9 flag vector", VEC[v][4:0]);
      chk_flags("R3 R4 model flags", flags_of(mq.size()));
    end

    // R6: empty latency through synchronizer
    do_reset();
    wr(1);
    chk("R6 empty after write edge", 32'(empty), 32'd1);
    cyc();
    chk("R6 empty after first read edge", 32'(empty), 32'd1);
    cyc();
    chk("R6 empty after second read edge", 32'(empty), 32'd0);
    rd("R6 read word", 1);
    chk("R6 empty at last read", 32'(empty), 32'd1);

    // R10: threshold loading
    do_reset();
    ofs_ld = 1; ofs_sel = 0; ofs_val = AW'(2); cyc();
    ofs_sel = 1; ofs_val = AW'(3); cyc();
    ofs_ld = 0; aeo = 2; afo = 3;
    wr(3); settle();
    chk_flags("R10 R8 level 3", flags_of(mq.size()));
    wr(9); settle();
    chk_flags("R10 R9 level 12", flags_of(mq.size()));
    wr(1); settle();
    chk_flags("R10 R9 level 13", flags_of(mq.size()));
    rd("R2 read", 11); settle();
    chk_flags("R10 R8 level 2", flags_of(mq.size()));

    // R11: retransmit replays from the first word
    do_reset();
    wr(5); settle();
    rd("R2 first pass", 5); settle();
    chk("R11 empty before rewind", 32'(empty), 32'd1);
    rt = 1'b1; ren = 1'b1; cyc(); rt = 1'b0; ren = 1'b0;
    chk("R11 rt beats ren, q held", 32'(q), 32'(last_q));
    chk("R11 not empty after rewind", 32'(empty), 32'd0);
    mq = hist;
    rd("R11 replay", 5);

    // R12: output enable
    oe = 1'b0; #1;
    chk("R12 q floats when oe=0", 32'(q !== last_q), 32'd1);
    oe = 1'b1; #1;
    chk("R12 q driven when oe=1", 32'(q), 32'(last_q));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule